// File: doc/BRIEF.md
# PWM Bridge Modulator with Minimum-Pulse Clamping

This block turns one audio channel's 6-bit quantized level into a one-bit pulse-width-modulated stream. A free-running period counter steps through 64 master-clock cycles for each switching period. The output is high from the start of the period for a number of cycles equal to the duty value. A new level can be strobed in at any time and is held pending. It is applied only at the period boundary, so a pulse is never cut short or stretched part-way through a period. A constant level therefore gives a constant duty cycle down to DC.

Before a level is applied it is clamped, so that neither the high phase nor the low phase of a period is shorter than a programmable minimum width. The modulated phase and its logical inverse feed a differential output stage. Each of the two outputs passes through its own delay line, programmable in whole master-clock cycles, so that switching edges can be staggered between outputs and channels. While enable is low, both outputs are forced low and the counter rests at zero.

Top module: `pwm_bridge_mod`

## Requirements
- R1: While enabled, the period counter visits 0,1,...,63 on successive clock edges, starting from 0 at the first edge that samples enable high. At each enabled edge, the positive phase is registered as 1 when the counter value sampled at that edge is below the applied duty value, and as 0 otherwise (left-aligned pulse). With delay 0 this phase appears directly on `out_pos_o`.
- R2: A sample presented with `smp_vld_i` high is stored, and a later strobe replaces an earlier one. The stored value is clamped and applied only at an enabled edge whose sampled count is 63; a strobe at that same edge is the one applied. The applied duty stays constant at all other edges, so a constant input gives a constant high time per period.
- R3: For a nonzero minimum setting M, a level whose value is below M produces M high cycles per period. This includes a level of 0.
- R4: For a nonzero minimum setting M, a level L with 64-L below M produces 64-M high cycles per period. This includes a level of 63.
- R5: A minimum setting of 0 disables clamping: level 0 gives a constantly low positive output, and level 63 gives 63 high cycles and 1 low cycle per period.
- R6: The minimum setting is sampled only at the edge where the new level is applied (count 63). A change made mid-period takes effect from the next period boundary.
- R7: The negative phase is the logical inverse of the positive phase while enabled, taken before the delay lines. With equal delays, `out_neg_o` equals the inverse of `out_pos_o`.
- R8: `out_pos_o` and `out_neg_o` each repeat their phase delayed by `dly_pos_i` and `dly_neg_i` clock cycles respectively (0 to 31). A setting of 0 passes the registered phase straight through.
- R9: At an edge that samples enable low, both outputs and both delay histories become 0 and the counter returns to 0. The stored sample still follows the strobe, and the applied duty is kept.
- R10: After a clock edge with `rst_ni` low, both outputs are 0, the counter is 0, and the stored sample and applied duty are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PWM master clock, 64 cycles per switching period |
| rst_ni | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Modulator enable; low holds outputs low and counter at 0 |
| smp_i | input | LVL_W (6) | Quantized level for the next period |
| smp_vld_i | input | 1 | Strobe that stores `smp_i` |
| min_pulse_i | input | MINP_W (5) | Shortest allowed high or low phase in cycles; 0 disables clamping |
| dly_pos_i | input | DLY_W (5) | Delay of the positive output in cycles |
| dly_neg_i | input | DLY_W (5) | Delay of the negative output in cycles |
| out_pos_o | output | 1 | Delayed positive PWM output |
| out_neg_o | output | 1 | Delayed negative (inverted) PWM output |

## Verification
The bench builds the block with its default parameters: 6 level bits, 5 minimum-pulse bits and 5 delay bits. With these values a whole switching period is only 64 cycles, so many periods fit into one run, with strobes landing at every counter phase including the boundary edge. Both extremes of the minimum setting (0 and 31) and both delay extremes (0 and 31) lie within reach. A behavioural model built from queues and integers predicts both outputs on every cycle, and directed windows count high cycles per period for the clamping corner cases.

// File: rtl/pwm_mod_pkg.sv
// Package: shared types for the PWM bridge modulator.
// Assumes nothing beyond IEEE 1800-2017.
package pwm_mod_pkg;
    // Pair of complementary phases that feed the two output lanes.
    typedef struct packed {
        logic neg;
        logic pos;
    } phase_pair_t;

    localparam int unsigned LANES = 2;
endpackage

// File: rtl/pwm_duty_clamp.sv
// Module: pwm_duty_clamp
// Combinational clamp that turns a raw level into a high time whose high
// and low phases are both at least min_i cycles long.
// Assumes MINP_W < LVL_W, so that the raise and lower rules cannot overlap.
module pwm_duty_clamp #(
    parameter int unsigned LVL_W  = 6,
    parameter int unsigned MINP_W = 5
) (
    input  logic [LVL_W-1:0]  raw_i,
    input  logic [MINP_W-1:0] min_i,
    output logic [LVL_W-1:0]  duty_o
);
    localparam int unsigned EXT_W  = LVL_W + 1;
    localparam int unsigned PERIOD = 1 << LVL_W;

    logic [EXT_W-1:0] raised;
    logic [EXT_W-1:0] low_time;
    logic [EXT_W-1:0] high_time;

    // Raise short high phases first, then cut back if the low phase got too short.
    always_comb begin
        raised    = (EXT_W'(raw_i) < EXT_W'(min_i)) ? EXT_W'(min_i) : EXT_W'(raw_i);
        low_time  = EXT_W'(PERIOD) - raised;
        high_time = (low_time < EXT_W'(min_i)) ? (EXT_W'(PERIOD) - EXT_W'(min_i)) : raised;
        duty_o    = high_time[LVL_W-1:0];
    end
endmodule

// File: rtl/pwm_period_gen.sv
// Module: pwm_period_gen
// Period counter, pending-sample store, applied-duty register and the
// registered complementary phase pair. The applied duty changes only at
// the last count of a period. The clamp sits outside this module: nxt_o
// goes out and the clamped value comes back on duty_c_i.
// Assumes a synchronous active-low reset and en_i synchronous to clk_i.
module pwm_period_gen
    import pwm_mod_pkg::*;
#(
    parameter int unsigned LVL_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [LVL_W-1:0] smp_i,
    input  logic             smp_vld_i,
    output logic [LVL_W-1:0] nxt_o,
    input  logic [LVL_W-1:0] duty_c_i,
    output phase_pair_t      ph_o
);
    localparam logic [LVL_W-1:0] LAST = '1;

    logic [LVL_W-1:0] cnt_q;
    logic [LVL_W-1:0] pend_q;
    logic [LVL_W-1:0] duty_q;
    phase_pair_t      ph_q;
    logic             wrap;
    logic             high_now;

    assign wrap     = (cnt_q == LAST);
    assign high_now = (cnt_q < duty_q);
    assign nxt_o    = smp_vld_i ? smp_i : pend_q;
    assign ph_o     = ph_q;

    // Hold the most recent strobed sample until the boundary uses it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        pend_q <= '0;
        else if (smp_vld_i) pend_q <= smp_i;
    end

    // Count master-clock cycles within the switching period.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    // Apply the clamped level at the period boundary only.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)            duty_q <= '0;
        else if (en_i && wrap)  duty_q <= duty_c_i;
    end

    // Register the left-aligned phase and its inverse; both low when idle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i) begin
            ph_q <= '0;
        end else begin
            ph_q.pos <= high_now;
            ph_q.neg <= !high_now;
        end
    end

    // R9: counter rests at zero while disabled
    assert_cnt_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (cnt_q == '0));

    // R2: applied duty only moves on an enabled boundary edge
    assert_duty_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(en_i && wrap) |=> $stable(duty_q));

    // R7: phases are complementary while running
    assert_complement_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> (ph_q.pos != ph_q.neg));
endmodule

// File: rtl/pwm_tap_delay.sv
// Module: pwm_tap_delay
// Shift-register delay line with a selectable tap; setting 0 bypasses it.
// Depth is 2**DLY_W - 1 stages. clr_i empties the history synchronously.
// Assumes DLY_W >= 2.
module pwm_tap_delay #(
    parameter int unsigned DLY_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             d_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             q_o
);
    localparam int unsigned DEPTH = (1 << DLY_W) - 1;

    logic [DEPTH-1:0] sr_q;
    logic [DLY_W-1:0] tap;

    assign tap = dly_i - 1'b1;
    assign q_o = (dly_i == '0) ? d_i : sr_q[tap];

    // Shift the phase history by one stage per cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) sr_q <= '0;
        else                  sr_q <= {sr_q[DEPTH-2:0], d_i};
    end

    // R8: a one-cycle setting repeats the previous input
    assert_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && dly_i == DLY_W'(1) && $past(rst_ni && !clr_i)) |-> (q_o == $past(d_i)));

    // R9: a cleared line emits zero from any nonzero tap
    assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> ((dly_i == '0) || (q_o == 1'b0)));
endmodule

// File: rtl/pwm_bridge_mod.sv
// Module: pwm_bridge_mod (top)
// One-channel PWM modulator: period generator, minimum-pulse clamp and one
// delay lane per differential output.
// Assumes MINP_W < LVL_W and all inputs synchronous to clk_i.
module pwm_bridge_mod
    import pwm_mod_pkg::*;
#(
    parameter int unsigned LVL_W  = 6,
    parameter int unsigned MINP_W = 5,
    parameter int unsigned DLY_W  = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [LVL_W-1:0]  smp_i,
    input  logic              smp_vld_i,
    input  logic [MINP_W-1:0] min_pulse_i,
    input  logic [DLY_W-1:0]  dly_pos_i,
    input  logic [DLY_W-1:0]  dly_neg_i,
    output logic              out_pos_o,
    output logic              out_neg_o
);
    localparam int unsigned EXT_W  = LVL_W + 1;
    localparam int unsigned PERIOD = 1 << LVL_W;

    logic [LVL_W-1:0] nxt_lvl;
    logic [LVL_W-1:0] duty_c;
    phase_pair_t      ph;
    logic             lane_in  [LANES];
    logic             lane_out [LANES];
    logic [DLY_W-1:0] lane_dly [LANES];

    pwm_period_gen #(.LVL_W(LVL_W)) i_gen (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .smp_i     (smp_i),
        .smp_vld_i (smp_vld_i),
        .nxt_o     (nxt_lvl),
        .duty_c_i  (duty_c),
        .ph_o      (ph)
    );

    pwm_duty_clamp #(.LVL_W(LVL_W), .MINP_W(MINP_W)) i_clamp (
        .raw_i  (nxt_lvl),
        .min_i  (min_pulse_i),
        .duty_o (duty_c)
    );

    // Route phase and delay setting to each lane.
    assign lane_in[0]  = ph.pos;
    assign lane_in[1]  = ph.neg;
    assign lane_dly[0] = dly_pos_i;
    assign lane_dly[1] = dly_neg_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pwm_tap_delay #(.DLY_W(DLY_W)) i_dly (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clr_i  (!en_i),
            .d_i    (lane_in[g]),
            .dly_i  (lane_dly[g]),
            .q_o    (lane_out[g])
        );
    end

    assign out_pos_o = lane_out[0];
    assign out_neg_o = lane_out[1];

    // R3: clamp never hands on a high phase shorter than the minimum
    assert_min_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        EXT_W'(duty_c) >= EXT_W'(min_pulse_i));

    // R4: clamp never leaves a low phase shorter than the minimum
    assert_min_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (EXT_W'(PERIOD) - EXT_W'(duty_c)) >= EXT_W'(min_pulse_i));

    // R9: outputs low one edge after enable is sampled low
    assert_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!out_pos_o && !out_neg_o));
endmodule

// File: tb/test_pwm_bridge_mod.sv
// Bench: behavioural per-cycle model plus directed pulse-width windows.
module test_pwm_bridge_mod;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [5:0] smp = '0;
    logic       vld = 1'b0;
    logic [4:0] minp = '0;
    logic [4:0] dpos = '0;
    logic [4:0] dneg = '0;
    logic       out_p;
    logic       out_n;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R10";

    // model state
    int m_cnt = 0, m_pend = 0, m_duty = 0;
    bit m_p = 0, m_n = 0;
    bit hp[$], hn[$];

    always #5 clk = ~clk;

    pwm_bridge_mod i_pwm_bridge_mod (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .smp_i(smp), .smp_vld_i(vld),
        .min_pulse_i(minp), .dly_pos_i(dpos), .dly_neg_i(dneg),
        .out_pos_o(out_p), .out_neg_o(out_n)
    );

    function automatic int clampf(int d, int m);
        int h = d;
        if (h < m) h = m;
        if (64 - h < m) h = 64 - m;
        return h;
    endfunction

    function automatic void zero_hist();
        hp.delete(); hn.delete();
        for (int i = 0; i < 31; i++) begin hp.push_back(0); hn.push_back(0); end
    endfunction

    initial zero_hist();

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pend = 0; m_duty = 0; m_p = 0; m_n = 0; zero_hist();
        end else if (!en) begin
            if (vld) m_pend = smp;
            m_cnt = 0; m_p = 0; m_n = 0; zero_hist();
        end else begin
            bit raw;
            hp.push_front(m_p); void'(hp.pop_back());
            hn.push_front(m_n); void'(hn.pop_back());
            raw = (m_cnt < m_duty);
            m_p = raw; m_n = !raw;
            if (m_cnt == 63) m_duty = clampf(vld ? int'(smp) : m_pend, int'(minp));
            if (vld) m_pend = smp;
            m_cnt = (m_cnt + 1) % 64;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare both outputs with the model every cycle, away from the edges.
    always begin
        @(posedge clk); #3;
        check(cur_req, "out_pos", out_p, (dpos == 0) ? m_p : hp[dpos-1]);
        check(cur_req, "out_neg", out_n, (dneg == 0) ? m_n : hn[dneg-1]);
    end

    task automatic strobe(int v);
        @(negedge clk); smp = 6'(v); vld = 1'b1;
        @(negedge clk); vld = 1'b0;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(string req, int exp);
        int hi = 0;
        repeat (64) begin @(negedge clk); hi += out_p; end
        check(req, "high cycles per period", hi, exp);
    endtask

    initial begin
        // R10: reset state
        cycles(3);
        check("R10", "out_pos in reset", out_p, 0);
        check("R10", "out_neg in reset", out_n, 0);
        rst_n = 1'b1;
        cycles(4);

        // R1: plain left-aligned pulse, no clamp
        cur_req = "R1";
        strobe(20); en = 1'b1;
        cycles(140);
        measure("R1", 20);

        // R3: raise short high phase
        cur_req = "R3";
        minp = 8; strobe(3); cycles(140); measure("R3", 8);
        strobe(0); cycles(140); measure("R3", 8);

        // R4: raise short low phase
        cur_req = "R4";
        strobe(60); cycles(140); measure("R4", 56);
        minp = 31; strobe(63); cycles(140); measure("R4", 33);

        // R5: clamping off at setting 0
        cur_req = "R5";
        minp = 0; strobe(0); cycles(140); measure("R5", 0);
        strobe(63); cycles(140); measure("R5", 63);
        minp = 1; strobe(0); cycles(140); measure("R5", 1);

        // R6: mid-period minimum changes only act at the boundary
        cur_req = "R6";
        for (int k = 0; k < 6; k++) begin
            strobe(2 + k);
            cycles(17 + 5 * k);
            minp = 5'(7 * k + 3);
            cycles(50);
        end

        // R2: strobes at many phases, later ones win
        cur_req = "R2";
        minp = 4;
        for (int k = 0; k < 40; k++) begin
            strobe((k * 13 + 5) % 64);
            cycles(k % 9);
        end
        cycles(130);

        // R8: independent delays including both extremes
        cur_req = "R8";
        strobe(25); dpos = 7; dneg = 31; cycles(200);
        dpos = 0; dneg = 31; cycles(100);
        dpos = 31; dneg = 0; cycles(100);
        dpos = 1; dneg = 2; cycles(100);

        // R7: equal delays give exact inverse on the pins
        cur_req = "R7";
        dpos = 4; dneg = 4; strobe(37); cycles(140);
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            check("R7", "out_neg vs ~out_pos", out_n, !out_p);
        end

        // R9: disable mid-period, outputs low, then restart from count 0
        cur_req = "R9";
        cycles(11);
        en = 1'b0;
        @(negedge clk);
        check("R9", "out_pos disabled", out_p, 0);
        check("R9", "out_neg disabled", out_n, 0);
        strobe(50);
        cycles(5);
        check("R9", "out_neg still low", out_n, 0);
        en = 1'b1;
        cycles(200);

        // R10: reset mid-run clears everything
        cur_req = "R10";
        rst_n = 1'b0; cycles(2);
        check("R10", "out_pos after reset", out_p, 0);
        rst_n = 1'b1; cycles(80);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule